// File: doc/BRIEF.md
# DMA Burst Splitter with 1 KB Boundary Cutting

This block accepts one block-transfer request from a DMA channel and breaks it into a series of bus bursts. Each burst is legal on the system bus. A request carries five fields: a start address, a transfer length counted in items, an item width code, a maximum burst length in beats, and a flag that holds the address fixed. Each burst the block emits carries a start address, a beat count and the beat size. The channel behind the block consumes one burst at a time through a valid/ready handshake.

The cutting is done in hardware, so software may program a single transfer that is far longer than 1 KB. With an incrementing address, every burst ends at the first of three limits:

- the programmed maximum burst length;
- the items still left in the request;
- the next 1024-byte address boundary.

With a fixed address, such as a peripheral FIFO port, the boundary limit does not apply. Only the burst-length limit and the remaining count shape the bursts.

The control is a five-state machine:

- **IDLE** asserts `req_ready`. A request handshake moves it to **CHECK**.
- **CHECK** examines the latched request. An illegal width code or a misaligned address moves it to **FAULT**. A zero length moves it to **DONE**. Any other request moves it to **OFFER**.
- **OFFER** presents one burst on the output.
  - A handshake on a burst that is not the last one stays in OFFER and presents the next burst.
  - A handshake on the last burst moves to **DONE**.
- **DONE** pulses `done` for one cycle and returns to IDLE.
- **FAULT** pulses `err` for one cycle and returns to IDLE.

Top module: `dma_burst_cutter`

## Requirements
- R1: With the incrementing address mode, no burst crosses a 1024-byte boundary. The burst's start address modulo 1024, plus beats times item bytes, never exceeds 1024.
- R2: Each burst's beat count is the smallest of three values: the decoded maximum burst length, the items still to transfer, and (incrementing mode only) the bytes left before the next 1024-byte boundary divided by the item bytes.
- R3: A maximum-length input of 1, 4, 8 or 16 is used as given. Every other value, including 0, is used as 1.
- R4: When `req_fixed` is 1, every burst of the request carries the request's start address, and bursts are not cut at 1024-byte boundaries.
- R5: Width code 0 means 1-byte items, 1 means 2-byte items and 2 means 4-byte items. `bst_size` repeats the request's code. Code 3 is rejected like a misaligned request.
- R6: A request whose address is not a multiple of the item bytes, or whose width code is 3, produces no burst. Two cycles after it is accepted, `err` is high for exactly one cycle. This check takes precedence over a zero length.
- R7: After each accepted burst, the next burst starts at the previous address plus the previous burst's byte length (incrementing mode). The remaining count falls by the beat count. The bursts' beats add up to the request length. `done` is high for exactly one cycle, in the cycle after the last burst handshake.
- R8: A request with a length of 0 produces no burst. `done` is high in the second cycle after the request is accepted.
- R9: While `bst_valid` is high and `bst_ready` is low, `bst_valid`, `bst_addr`, `bst_beats` and `bst_size` hold their values into the next cycle.
- R10: `req_ready` is high only in IDLE. It is high after reset, and it stays low from the cycle after a request is accepted until the cycle after `done` or `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Transfer length in items (0 to 4095) |
| req_size | input | 2 | Item width code: 0=1 B, 1=2 B, 2=4 B |
| req_maxlen | input | BEAT_W | Maximum burst length in beats (1, 4, 8, 16; other values mean 1) |
| req_fixed | input | 1 | 1 = address does not advance |
| bst_valid | output | 1 | Burst presented |
| bst_ready | input | 1 | Burst taken by the bus side |
| bst_addr | output | ADDR_W | Burst start address |
| bst_beats | output | BEAT_W | Beats in the burst (1 to 16) |
| bst_size | output | 2 | Beat size code, same encoding as req_size |
| done | output | 1 | One-cycle pulse: request completed |
| err | output | 1 | One-cycle pulse: request rejected |

## Verification
The sweep places start addresses a few items below a 1 KB boundary for every width and length code. A design that ignored the boundary would emit a burst that spills into the next kilobyte. A design that cut at the boundary in fixed mode would shorten bursts that should be full length. The sweep feeds unsupported length codes such as 0, 2, 5 and 31, which catches a decoder that passes the raw value through. It checks the final short burst where the remaining count is below the length limit. Back-pressure on the burst side catches outputs that move before a handshake. Misaligned and zero-length requests catch a design that emits a burst anyway, or that reports completion in the wrong cycle.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_OFFER = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } bsc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

endpackage

// File: rtl/bsc_req_decode.sv
`timescale 1ns/1ps
// Decodes a latched request: item shift, legal burst length and alignment fault.
module bsc_req_decode
    import bsc_pkg::*;
#(
    parameter int BEAT_W = 5
) (
    input  logic [1:0]        size_code,
    input  logic [BEAT_W-1:0] maxlen_raw,
    input  logic [1:0]        addr_lo,
    output logic [1:0]        shift,
    output logic [BEAT_W-1:0] max_beats,
    output logic              bad
);

    localparam int N_LEGAL = 4;
    localparam int LEGAL_LEN [N_LEGAL] = '{1, 4, 8, 16};

    logic [N_LEGAL-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N_LEGAL; g++) begin : g_len
            assign hit[g] = (maxlen_raw == BEAT_W'(LEGAL_LEN[g]));
        end
    endgenerate

    always_comb begin
        max_beats = (|hit) ? maxlen_raw : BEAT_W'(1);
    end

    always_comb begin
        shift = size_code;
        unique case (size_code)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = addr_lo[0];
            SZ_WORD: bad = (addr_lo != 2'b00);
            SZ_BAD:  bad = 1'b1;
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/bsc_burst_calc.sv
`timescale 1ns/1ps
// Computes the beat count and byte length of the burst at the current address.
module bsc_burst_calc #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 12,
    parameter int BEAT_W   = 5,
    parameter int BND_LOG2 = 10
) (
    input  logic [BND_LOG2-1:0] addr_lo,
    input  logic [CNT_W-1:0]    remaining,
    input  logic [1:0]          shift,
    input  logic [BEAT_W-1:0]   max_beats,
    input  logic                fixed,
    output logic [BEAT_W-1:0]   beats,
    output logic [ADDR_W-1:0]   bytes
);

    localparam int RW = BND_LOG2 + 1;
    localparam logic [RW-1:0] BND_BYTES = {1'b1, {BND_LOG2{1'b0}}};

    logic [RW-1:0]     room_bytes;
    logic [RW-1:0]     room_beats;
    logic [BEAT_W-1:0] by_count;

    always_comb begin
        room_bytes = BND_BYTES - {1'b0, addr_lo};
        room_beats = room_bytes >> shift;
    end

    always_comb begin
        by_count = (remaining < CNT_W'(max_beats)) ? remaining[BEAT_W-1:0] : max_beats;
        if (!fixed && (room_beats < RW'(by_count))) begin
            beats = room_beats[BEAT_W-1:0];
        end else begin
            beats = by_count;
        end
        bytes = ADDR_W'(beats) << shift;
    end

endmodule

// File: rtl/dma_burst_cutter.sv
`timescale 1ns/1ps
// Splits one DMA block request into bursts limited by length and 1 KB boundaries.
module dma_burst_cutter
    import bsc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 12,
    parameter int BEAT_W   = 5,
    parameter int BND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [1:0]        req_size,
    input  logic [BEAT_W-1:0] req_maxlen,
    input  logic              req_fixed,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [BEAT_W-1:0] bst_beats,
    output logic [1:0]        bst_size,
    output logic              done,
    output logic              err
);

    bsc_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [1:0]        size_q;
    logic [BEAT_W-1:0] maxraw_q;
    logic              fixed_q;

    logic [1:0]        shift;
    logic [BEAT_W-1:0] max_beats;
    logic              bad;
    logic [BEAT_W-1:0] beats;
    logic [ADDR_W-1:0] bytes;
    logic              take_req;
    logic              take_bst;
    logic              last_bst;

    bsc_req_decode #(
        .BEAT_W (BEAT_W)
    ) u_dec (
        .size_code  (size_q),
        .maxlen_raw (maxraw_q),
        .addr_lo    (addr_q[1:0]),
        .shift      (shift),
        .max_beats  (max_beats),
        .bad        (bad)
    );

    bsc_burst_calc #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .BEAT_W   (BEAT_W),
        .BND_LOG2 (BND_LOG2)
    ) u_calc (
        .addr_lo   (addr_q[BND_LOG2-1:0]),
        .remaining (rem_q),
        .shift     (shift),
        .max_beats (max_beats),
        .fixed     (fixed_q),
        .beats     (beats),
        .bytes     (bytes)
    );

    assign take_req = (state_q == ST_IDLE) && req_valid;
    assign take_bst = (state_q == ST_OFFER) && bst_ready;
    assign last_bst = (rem_q == CNT_W'(beats));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (bad)                      state_d = ST_FAULT;
                else if (rem_q == '0)         state_d = ST_DONE;
                else                          state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (bst_ready && last_bst)    state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request and progress registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rem_q    <= '0;
            size_q   <= SZ_BYTE;
            maxraw_q <= '0;
            fixed_q  <= 1'b0;
        end else if (take_req) begin
            addr_q   <= req_addr;
            rem_q    <= req_count;
            size_q   <= req_size;
            maxraw_q <= req_maxlen;
            fixed_q  <= req_fixed;
        end else if (take_bst) begin
            if (!fixed_q) begin
                addr_q <= addr_q + bytes;
            end
            rem_q <= rem_q - CNT_W'(beats);
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        bst_valid = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_CHECK: ;
            ST_OFFER: bst_valid = 1'b1;
            ST_DONE:  done      = 1'b1;
            ST_FAULT: err       = 1'b1;
            default:  ;
        endcase
    end

    assign bst_addr  = addr_q;
    assign bst_beats = beats;
    assign bst_size  = size_q;

endmodule

// File: rtl/bsc_checker.sv
`timescale 1ns/1ps
// Property checker attached to the burst splitter.
module bsc_checker #(
    parameter int ADDR_W   = 32,
    parameter int BEAT_W   = 5,
    parameter int BND_LOG2 = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bst_valid,
    input logic              bst_ready,
    input logic [ADDR_W-1:0] bst_addr,
    input logic [BEAT_W-1:0] bst_beats,
    input logic [1:0]        bst_size,
    input logic              done,
    input logic              err,
    input logic              fixed_q
);

    localparam int RW = BND_LOG2 + 2;
    localparam logic [RW-1:0] LIMIT = RW'(1) << BND_LOG2;

    logic [RW-1:0] end_off;
    assign end_off = RW'(bst_addr[BND_LOG2-1:0]) + (RW'(bst_beats) << bst_size);

    p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !fixed_q) |-> (end_off <= LIMIT));

    p_beats_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_beats != '0) && (bst_beats <= BEAT_W'(16)));

    p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready && fixed_q) |=> (!bst_valid || $stable(bst_addr)));

    p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_size != 2'd3) &&
                      ((bst_size != 2'd1) || !bst_addr[0]) &&
                      ((bst_size != 2'd2) || (bst_addr[1:0] == 2'b00)));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bst_valid && !done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> bst_valid && $stable(bst_addr) &&
                                      $stable(bst_beats) && $stable(bst_size));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid || done || err) |-> !req_ready);

endmodule

bind dma_burst_cutter bsc_checker #(
    .ADDR_W   (ADDR_W),
    .BEAT_W   (BEAT_W),
    .BND_LOG2 (BND_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bst_valid (bst_valid),
    .bst_ready (bst_ready),
    .bst_addr  (bst_addr),
    .bst_beats (bst_beats),
    .bst_size  (bst_size),
    .done      (done),
    .err       (err),
    .fixed_q   (fixed_q)
);

// File: tb/sim_dma_burst_cutter.sv
`timescale 1ns/1ps
module sim_dma_burst_cutter;

    localparam int AW = 32;
    localparam int CW = 12;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic [1:0]    req_size = '0;
    logic [BW-1:0] req_maxlen = '0;
    logic          req_fixed = 1'b0;
    logic          bst_valid;
    logic          bst_ready = 1'b0;
    logic [AW-1:0] bst_addr;
    logic [BW-1:0] bst_beats;
    logic [1:0]    bst_size;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_burst_cutter u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .req_size(req_size),
        .req_maxlen(req_maxlen), .req_fixed(req_fixed),
        .bst_valid(bst_valid), .bst_ready(bst_ready),
        .bst_addr(bst_addr), .bst_beats(bst_beats), .bst_size(bst_size),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int legal_len(input int code);
        if (code == 1 || code == 4 || code == 8 || code == 16) return code;
        return 1;
    endfunction

    // Drive one request and follow it to done or err, checking every burst.
    task automatic run_req(input logic [AW-1:0] a, input int cnt, input int sz,
                           input int ml, input bit fx, input bit stall);
        bit      expect_bad;
        int      w;
        longint  exp_addr;
        int      exp_rem;
        int      last_hs;
        bit      fin;
        bit      saw;
        bit      held;
        logic [AW-1:0] p_addr;
        logic [BW-1:0] p_beats;
        expect_bad = (sz == 3) || (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 2'b00);
        w = 1 << sz;
        chk(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        req_addr   = a;
        req_count  = CW'(cnt);
        req_size   = 2'(sz);
        req_maxlen = BW'(ml);
        req_fixed  = fx;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        exp_addr = a;
        exp_rem  = cnt;
        last_hs  = -10;
        fin = 0; saw = 0; held = 0;
        p_addr = '0; p_beats = '0;
        for (int cyc = 0; cyc < 40000 && !fin; cyc++) begin
            bit rdy;
            rdy = stall ? ((cyc % 3) != 0) : 1'b1;
            bst_ready = rdy;
            chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
            if (err) begin
                fin = 1;
                chk(expect_bad, "R6", "unexpected err", 1, 0);
                chk(!saw, "R6", "burst before err", saw, 0);
                chk(cyc == 1, "R6", "err cycle", cyc, 1);
            end else if (done) begin
                fin = 1;
                chk(!expect_bad, "R6", "done instead of err", 1, 0);
                chk(exp_rem == 0, "R7", "items left at done", exp_rem, 0);
                if (cnt == 0) chk(cyc == 1, "R8", "zero-length done cycle", cyc, 1);
                else          chk(cyc == last_hs + 1, "R7", "done cycle", cyc, last_hs + 1);
            end else if (bst_valid) begin
                int m;
                saw = 1;
                m = legal_len(ml);
                if (exp_rem < m) m = exp_rem;
                if (!fx) begin
                    int room;
                    room = (1024 - int'(exp_addr % 1024)) / w;
                    if (room < m) m = room;
                end
                if (held) begin
                    chk(bst_addr == p_addr && bst_beats == p_beats, "R9",
                        "burst changed under back-pressure", bst_beats, p_beats);
                end
                chk(!expect_bad, "R6", "burst for bad request", 1, 0);
                chk(bst_beats == BW'(m), "R2/R3", "beats", bst_beats, m);
                chk(bst_size == 2'(sz), "R5", "size code", bst_size, sz);
                if (fx) chk(bst_addr == a, "R4", "fixed address", bst_addr, a);
                else    chk(bst_addr == AW'(exp_addr), "R7", "address", bst_addr, exp_addr);
                if (!fx) chk((int'(bst_addr % 1024) + int'(bst_beats) * w) <= 1024, "R1",
                             "boundary crossing end", int'(bst_addr % 1024) + int'(bst_beats) * w, 1024);
                held = !rdy;
                p_addr = bst_addr;
                p_beats = bst_beats;
                if (rdy) begin
                    if (!fx) exp_addr = exp_addr + longint'(m * w);
                    exp_rem = exp_rem - m;
                    last_hs = cyc;
                end
            end
            @(negedge clk);
        end
        bst_ready = 1'b0;
        if (!fin) chk(1'b0, "R7", "request never completed", 0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int codes [8] = '{1, 4, 8, 16, 0, 5, 31, 2};
        int offs  [4] = '{0, 1020, 1000, 964};
        int cnts  [3] = '{1, 7, 33};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R10)
        chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
        chk(bst_valid == 1'b0, "R10", "reset valid", bst_valid, 0);
        chk(done == 1'b0 && err == 1'b0, "R7", "reset pulses", {done, err}, 0);

        // sweep: widths, length codes, modes, offsets near a boundary, lengths
        for (int sz = 0; sz < 3; sz++)
            for (int mi = 0; mi < 8; mi++)
                for (int fx = 0; fx < 2; fx++)
                    for (int ai = 0; ai < 4; ai++)
                        for (int ci = 0; ci < 3; ci++)
                            run_req(32'h0000_2000 + AW'(offs[ai]), cnts[ci], sz,
                                    codes[mi], fx[0], ((mi + ai + ci) % 2) == 1);

        // long requests spanning many boundaries
        run_req(32'h0001_03F8, 4095, 2, 16, 1'b0, 1'b0);
        run_req(32'h0001_0001, 4095, 0, 16, 1'b0, 1'b1);
        run_req(32'h0001_0002, 600, 1, 8, 1'b1, 1'b0);

        // rejected requests (R6) and zero length (R8)
        run_req(32'h0000_3001, 4, 1, 4, 1'b0, 1'b0);
        run_req(32'h0000_3002, 4, 2, 4, 1'b0, 1'b0);
        run_req(32'h0000_3003, 4, 2, 4, 1'b1, 1'b0);
        run_req(32'h0000_3000, 4, 3, 4, 1'b0, 1'b0);
        run_req(32'h0000_3001, 0, 2, 4, 1'b0, 1'b0);
        run_req(32'h0000_3000, 0, 0, 16, 1'b0, 1'b0);
        run_req(32'h0000_33FC, 0, 2, 1, 1'b1, 1'b0);

        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "idle at end", req_ready, 1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule